// File: doc/BRIEF.md
# Hardware Task Switch Sequencer

This controller carries out a hardware task switch between two task-state records kept in a word-addressed memory. A request names the cause of the switch, the target task's selector and record base, and the fields of its descriptor (privilege level, present bit, limit, busy bit), together with the current privilege level. The sequencer first decides whether the switch is permitted. If a check fails, it reports a fault code and changes nothing.

When all checks pass, the sequencer works in a fixed order:
- It writes the live register image into the outgoing task's record. The base of that record comes from the task register.
- It points the task register at the incoming task.
- For nesting causes, it records the outgoing selector in the incoming record's back-link word.
- It reads the incoming record into the register image.
- It issues strobes that update the busy flags in the two descriptors.
- It signals completion.

A return-from-interrupt takes its target selector from the back-link word of the outgoing record, not from the request.

The register image lives inside the block. The surrounding core can overwrite single words of it and observes all of it on an output bus. Memory traffic uses a single-word request/acknowledge port with one access in flight at a time.

Top module: `task_switch_seq`

## Requirements
- R1: For cause 0 (jump) and cause 1 (call), the switch faults with code 1 when the current privilege level or the requested level in bits [1:0] of the selector is numerically greater than the descriptor privilege level.
- R2: Cause 3 (software interrupt) faults with code 1 when the descriptor privilege level is below the current privilege level. Cause 2 (return) and cause 4 (exception or external interrupt) never raise code 1.
- R3: When privilege passes, a descriptor that is not present, or whose limit is below 0x67, faults with code 2. A limit of exactly 0x67 is accepted. A privilege fault takes precedence.
- R4: After the earlier checks, the switch faults with code 3 in two cases: a return whose target is not busy, or any other cause whose target is busy.
- R5: A fault is reported as a one-cycle `fault_o` pulse in the cycle after the start is accepted. A faulting request makes no memory access and no flag strobe, and leaves the task register and the register image unchanged.
- R6: On a permitted switch, image word k is written to old base + 1 + k for k = 0 to N-1, in ascending order. Word 0 holds the flags, and the nested-task flag is bit 14.
- R7: Every save write happens while the task register still holds the old selector. Every load read of the new record happens after the task register holds the new selector and base.
- R8: For causes 1, 3 and 4, the old selector is written into word 0 (the back-link) of the new record. For causes 0 and 2, that word is left untouched.
- R9: The image is reloaded from new base + 1 + k for k = 0 to N-1.
- R10: For causes 0 and 2, a flag strobe with value 0 names the old selector. For causes other than 2, a flag strobe with value 1 names the new selector.
- R11: For cause 2 only, bit 14 of the saved flags word is written as 0. Other causes save it unchanged.
- R12: For causes 1, 3 and 4, bit 14 of the loaded flags is forced to 1. Causes 0 and 2 keep the loaded value.
- R13: For cause 2, the new selector is the low selector-width bits of the word at old base + 0.
- R14: `done_o` pulses for exactly one cycle after the flag phase. A start raised while a switch is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Request a switch (taken when idle) |
| cause_i | input | 3 | Switch cause: 0 jump, 1 call, 2 return, 3 software interrupt, 4 exception/interrupt |
| sel_i | input | SW | Target selector (bits [1:0] are the requested level) |
| base_i | input | AW | Word base of the target record |
| dpl_i | input | 2 | Target descriptor privilege level |
| present_i | input | 1 | Target descriptor present bit |
| limit_i | input | LW | Target descriptor limit |
| busy_i | input | 1 | Target descriptor busy bit |
| cpl_i | input | 2 | Current privilege level |
| img_we_i | input | 1 | Write one image word from the core |
| img_idx_i | input | IW | Index of the image word to write |
| img_wdata_i | input | DW | Data for the image word |
| img_o | output | NREGS*DW | Whole register image, word k at bits [k*DW +: DW] |
| tr_sel_o | output | SW | Task register selector |
| tr_base_o | output | AW | Task register record base |
| active_o | output | 1 | A switch is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | One-cycle fault pulse |
| fault_code_o | output | 2 | 1 protection, 2 invalid target, 3 busy mismatch |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | DW | Write data |
| mem_ack_i | input | 1 | Access completes in this cycle |
| mem_rdata_i | input | DW | Read data, valid with acknowledge |
| flag_we_o | output | 1 | Descriptor busy-flag update strobe |
| flag_sel_o | output | SW | Selector whose busy flag is updated |
| flag_val_o | output | 1 | New busy-flag value |

## Verification
The assertions rely on the memory side completing an access only when the access is requested. They also rely on the core not writing the image while a switch is in progress, and on the descriptor inputs describing the task that the request (or the back-link, for a return) actually names.

The bench's memory model acknowledges each request after half a cycle and drops the acknowledge for a cycle between accesses. The bench writes the image only between switches. For a return, it supplies the base and busy state of the task that the stored back-link points to.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

  typedef enum logic [2:0] {
    CS_JMP   = 3'd0,
    CS_CALL  = 3'd1,
    CS_IRET  = 3'd2,
    CS_SWINT = 3'd3,
    CS_EXT   = 3'd4
  } cause_e;

  typedef enum logic [1:0] {
    FT_NONE = 2'd0,
    FT_GP   = 2'd1,
    FT_TASK = 2'd2,
    FT_BUSY = 2'd3
  } fault_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LINK_RD,
    ST_SAVE,
    ST_TR,
    ST_LINK_WR,
    ST_LOAD,
    ST_FLAG_OLD,
    ST_FLAG_NEW
  } state_e;

  function automatic logic is_return(input logic [2:0] c);
    return c == CS_IRET;
  endfunction

  // call, software interrupt, exception/interrupt (codes above 4 act as 4)
  function automatic logic nests(input logic [2:0] c);
    return (c == CS_CALL) || (c == CS_SWINT) || (c >= CS_EXT);
  endfunction

  function automatic logic drops_old_busy(input logic [2:0] c);
    return (c == CS_JMP) || (c == CS_IRET);
  endfunction

  function automatic logic priv_denied(input logic [2:0] c, input logic [1:0] cpl,
                                       input logic [1:0] rpl, input logic [1:0] dpl);
    if (c == CS_JMP || c == CS_CALL) return (cpl > dpl) || (rpl > dpl);
    if (c == CS_SWINT)               return dpl < cpl;
    return 1'b0;
  endfunction

  function automatic logic busy_wrong(input logic [2:0] c, input logic busy);
    return is_return(c) ? !busy : busy;
  endfunction

endpackage

// File: rtl/tsw_check.sv
module tsw_check
  import tsw_pkg::*;
#(
  parameter int          LW        = 20,
  parameter int unsigned MIN_LIMIT = 32'h67
) (
  input  logic [2:0]    cause_i,
  input  logic [1:0]    cpl_i,
  input  logic [1:0]    rpl_i,
  input  logic [1:0]    dpl_i,
  input  logic          present_i,
  input  logic [LW-1:0] limit_i,
  input  logic          busy_i,
  output logic [1:0]    code_o
);
  logic limit_ok;
  assign limit_ok = 32'(limit_i) >= MIN_LIMIT;

  // priority: privilege, then descriptor validity, then busy state
  always_comb begin
    if (priv_denied(cause_i, cpl_i, rpl_i, dpl_i)) code_o = FT_GP;
    else if (!present_i || !limit_ok)              code_o = FT_TASK;
    else if (busy_wrong(cause_i, busy_i))          code_o = FT_BUSY;
    else                                           code_o = FT_NONE;
  end
endmodule

// File: rtl/tsw_image.sv
module tsw_image #(
  parameter int DW        = 32,
  parameter int NREGS     = 8,
  parameter int IW        = 3,
  parameter int FLAGS_IDX = 0,
  parameter int NT_BIT    = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ext_we_i,
  input  logic [IW-1:0]       ext_idx_i,
  input  logic [DW-1:0]       ext_data_i,
  input  logic                ld_we_i,
  input  logic [IW-1:0]       ld_idx_i,
  input  logic [DW-1:0]       ld_data_i,
  input  logic                nt_set_i,
  input  logic [IW-1:0]       sv_idx_i,
  input  logic                nt_clr_i,
  output logic [DW-1:0]       sv_word_o,
  output logic [NREGS*DW-1:0] img_o
);
  logic [DW-1:0] img_q [NREGS];

  function automatic logic [DW-1:0] nt_force(input logic [DW-1:0] w, input logic on,
                                             input logic val);
    logic [DW-1:0] r;
    r = w;
    if (on) r[NT_BIT] = val;
    return r;
  endfunction

  logic ld_is_flags, sv_is_flags;
  assign ld_is_flags = ld_idx_i == IW'(FLAGS_IDX);
  assign sv_is_flags = sv_idx_i == IW'(FLAGS_IDX);

  assign sv_word_o = nt_force(img_q[sv_idx_i], sv_is_flags && nt_clr_i, 1'b0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREGS; k++) img_q[k] <= '0;
    end else if (ld_we_i) begin
      img_q[ld_idx_i] <= nt_force(ld_data_i, ld_is_flags && nt_set_i, 1'b1);
    end else if (ext_we_i) begin
      img_q[ext_idx_i] <= ext_data_i;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NREGS; g++) begin : g_flat
      assign img_o[g*DW +: DW] = img_q[g];
    end
  endgenerate

  assert_nt_forced_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we_i && ld_is_flags && nt_set_i |=> img_o[FLAGS_IDX*DW + NT_BIT]);

  assert_ld_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_we_i && ext_we_i));
endmodule

// File: rtl/tsw_fsm.sv
module tsw_fsm
  import tsw_pkg::*;
#(
  parameter int             DW          = 32,
  parameter int             AW          = 16,
  parameter int             SW          = 16,
  parameter int             NREGS       = 8,
  parameter int             IW          = 3,
  parameter logic [SW-1:0]  TR_RST_SEL  = '0,
  parameter logic [AW-1:0]  TR_RST_BASE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [2:0]    cause_i,
  input  logic [SW-1:0] sel_i,
  input  logic [AW-1:0] base_i,
  input  logic [1:0]    fcode_i,
  output logic [SW-1:0] tr_sel_o,
  output logic [AW-1:0] tr_base_o,
  output logic          active_o,
  output logic          done_o,
  output logic          fault_o,
  output logic [1:0]    fault_code_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          flag_we_o,
  output logic [SW-1:0] flag_sel_o,
  output logic          flag_val_o,
  output logic          ld_we_o,
  output logic [IW-1:0] idx_o,
  output logic          nt_clr_o,
  output logic          nt_set_o,
  input  logic [DW-1:0] sv_word_i
);
  state_e        st_q;
  logic [IW-1:0] cnt_q;
  logic [2:0]    cause_q;
  logic [SW-1:0] nsel_q, osel_q;
  logic [AW-1:0] nbase_q;

  logic accept, xfer, last;
  assign accept = start_i && (st_q == ST_IDLE);
  assign xfer   = mem_req_o && mem_ack_i;
  assign last   = cnt_q == IW'(NREGS - 1);

  function automatic logic [AW-1:0] word_addr(input logic [AW-1:0] b, input logic [IW-1:0] i);
    return b + AW'(i) + AW'(1);
  endfunction

  assign active_o = st_q != ST_IDLE;
  assign idx_o    = cnt_q;
  assign ld_we_o  = (st_q == ST_LOAD) && xfer;
  assign nt_clr_o = is_return(cause_q);
  assign nt_set_o = nests(cause_q);

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    flag_we_o   = 1'b0;
    flag_sel_o  = '0;
    flag_val_o  = 1'b0;
    case (st_q)
      ST_LINK_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = tr_base_o;
      end
      ST_SAVE: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = word_addr(tr_base_o, cnt_q);
        mem_wdata_o = sv_word_i;
      end
      ST_LINK_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = nbase_q;
        mem_wdata_o = DW'(osel_q);
      end
      ST_LOAD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = word_addr(nbase_q, cnt_q);
      end
      ST_FLAG_OLD: begin
        flag_we_o  = drops_old_busy(cause_q);
        flag_sel_o = osel_q;
        flag_val_o = 1'b0;
      end
      ST_FLAG_NEW: begin
        flag_we_o  = !is_return(cause_q);
        flag_sel_o = nsel_q;
        flag_val_o = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      cnt_q        <= '0;
      cause_q      <= '0;
      nsel_q       <= '0;
      osel_q       <= '0;
      nbase_q      <= '0;
      tr_sel_o     <= TR_RST_SEL;
      tr_base_o    <= TR_RST_BASE;
      done_o       <= 1'b0;
      fault_o      <= 1'b0;
      fault_code_o <= '0;
    end else begin
      done_o  <= 1'b0;
      fault_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (accept) begin
          if (fcode_i != FT_NONE) begin
            fault_o      <= 1'b1;
            fault_code_o <= fcode_i;
          end else begin
            cause_q <= cause_i;
            nsel_q  <= sel_i;
            nbase_q <= base_i;
            osel_q  <= tr_sel_o;
            cnt_q   <= '0;
            st_q    <= is_return(cause_i) ? ST_LINK_RD : ST_SAVE;
          end
        end
        ST_LINK_RD: if (xfer) begin
          nsel_q <= mem_rdata_i[SW-1:0];
          st_q   <= ST_SAVE;
        end
        ST_SAVE: if (xfer) begin
          cnt_q <= last ? '0 : cnt_q + 1'b1;
          if (last) st_q <= ST_TR;
        end
        ST_TR: begin
          tr_sel_o  <= nsel_q;
          tr_base_o <= nbase_q;
          st_q      <= nests(cause_q) ? ST_LINK_WR : ST_LOAD;
        end
        ST_LINK_WR: if (xfer) st_q <= ST_LOAD;
        ST_LOAD: if (xfer) begin
          cnt_q <= last ? '0 : cnt_q + 1'b1;
          if (last) st_q <= ST_FLAG_OLD;
        end
        ST_FLAG_OLD: st_q <= ST_FLAG_NEW;
        ST_FLAG_NEW: begin
          done_o <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_hold_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  assert_fault_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !mem_req_o && !flag_we_o && !active_o);

  assert_gp_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o && fault_code_o == FT_GP |->
      $past(cause_i) != CS_IRET && $past(cause_i) != CS_EXT);

  assert_done_single_R14: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_new_set_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_o && flag_val_o |-> flag_sel_o == tr_sel_o);
endmodule

// File: rtl/task_switch_seq.sv
module task_switch_seq
  import tsw_pkg::*;
#(
  parameter int             DW          = 32,
  parameter int             AW          = 16,
  parameter int             SW          = 16,
  parameter int             LW          = 20,
  parameter int             NREGS       = 8,
  parameter int             FLAGS_IDX   = 0,
  parameter int             NT_BIT      = 14,
  parameter int unsigned    MIN_LIMIT   = 32'h67,
  parameter logic [SW-1:0]  TR_RST_SEL  = 16'h0010,
  parameter logic [AW-1:0]  TR_RST_BASE = 16'h0040,
  localparam int            IW          = $clog2(NREGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [2:0]          cause_i,
  input  logic [SW-1:0]       sel_i,
  input  logic [AW-1:0]       base_i,
  input  logic [1:0]          dpl_i,
  input  logic                present_i,
  input  logic [LW-1:0]       limit_i,
  input  logic                busy_i,
  input  logic [1:0]          cpl_i,
  input  logic                img_we_i,
  input  logic [IW-1:0]       img_idx_i,
  input  logic [DW-1:0]       img_wdata_i,
  output logic [NREGS*DW-1:0] img_o,
  output logic [SW-1:0]       tr_sel_o,
  output logic [AW-1:0]       tr_base_o,
  output logic                active_o,
  output logic                done_o,
  output logic                fault_o,
  output logic [1:0]          fault_code_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [AW-1:0]       mem_addr_o,
  output logic [DW-1:0]       mem_wdata_o,
  input  logic                mem_ack_i,
  input  logic [DW-1:0]       mem_rdata_i,
  output logic                flag_we_o,
  output logic [SW-1:0]       flag_sel_o,
  output logic                flag_val_o
);
  logic [1:0]    fcode;
  logic          ld_we, nt_clr, nt_set;
  logic [IW-1:0] idx;
  logic [DW-1:0] sv_word;

  tsw_check #(.LW(LW), .MIN_LIMIT(MIN_LIMIT)) u_check (
    .cause_i(cause_i), .cpl_i(cpl_i), .rpl_i(sel_i[1:0]), .dpl_i(dpl_i),
    .present_i(present_i), .limit_i(limit_i), .busy_i(busy_i), .code_o(fcode)
  );

  tsw_fsm #(.DW(DW), .AW(AW), .SW(SW), .NREGS(NREGS), .IW(IW),
            .TR_RST_SEL(TR_RST_SEL), .TR_RST_BASE(TR_RST_BASE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cause_i(cause_i),
    .sel_i(sel_i), .base_i(base_i), .fcode_i(fcode),
    .tr_sel_o(tr_sel_o), .tr_base_o(tr_base_o), .active_o(active_o),
    .done_o(done_o), .fault_o(fault_o), .fault_code_o(fault_code_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .flag_we_o(flag_we_o), .flag_sel_o(flag_sel_o), .flag_val_o(flag_val_o),
    .ld_we_o(ld_we), .idx_o(idx), .nt_clr_o(nt_clr), .nt_set_o(nt_set),
    .sv_word_i(sv_word)
  );

  tsw_image #(.DW(DW), .NREGS(NREGS), .IW(IW), .FLAGS_IDX(FLAGS_IDX),
              .NT_BIT(NT_BIT)) u_image (
    .clk(clk), .rst_n(rst_n),
    .ext_we_i(img_we_i), .ext_idx_i(img_idx_i), .ext_data_i(img_wdata_i),
    .ld_we_i(ld_we), .ld_idx_i(idx), .ld_data_i(mem_rdata_i), .nt_set_i(nt_set),
    .sv_idx_i(idx), .nt_clr_i(nt_clr), .sv_word_o(sv_word), .img_o(img_o)
  );
endmodule

// File: tb/tb_task_switch_seq.sv
module tb_task_switch_seq;
  localparam int N  = 8;
  localparam int NT = 14;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0, start = 1'b0, present = 1'b0, busy = 1'b0;
  logic [2:0]    cause = '0;
  logic [15:0]   sel = '0, base = '0;
  logic [1:0]    dpl = '0, cpl = '0;
  logic [19:0]   limit = '0;
  logic          img_we = 1'b0;
  logic [2:0]    img_idx = '0;
  logic [31:0]   img_wd = '0;
  logic [N*32-1:0] img;
  logic [15:0]   tr_sel, tr_base, mem_addr, flag_sel;
  logic          active, done, fault, mem_req, mem_we, flag_we, flag_val;
  logic [1:0]    fcode;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          mem_ack = 1'b0;

  task_switch_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cause_i(cause), .sel_i(sel),
    .base_i(base), .dpl_i(dpl), .present_i(present), .limit_i(limit), .busy_i(busy),
    .cpl_i(cpl), .img_we_i(img_we), .img_idx_i(img_idx), .img_wdata_i(img_wd),
    .img_o(img), .tr_sel_o(tr_sel), .tr_base_o(tr_base), .active_o(active),
    .done_o(done), .fault_o(fault), .fault_code_o(fcode), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata), .flag_we_o(flag_we),
    .flag_sel_o(flag_sel), .flag_val_o(flag_val)
  );

  logic [31:0] mem [256];
  logic        poke_en = 1'b0;
  logic [7:0]  poke_a = '0;
  logic [31:0] poke_d = '0;
  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) begin
    if (mem_req && mem_ack && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    else if (poke_en)                 mem[poke_a] <= poke_d;
  end

  int total = 0, bad = 0, cyc = 0;
  int acc_n = 0, oclr_n = 0, nset_n = 0, done_n = 0;
  logic [15:0] oclr_sel = '0, nset_sel = '0;
  logic [15:0] m_old_sel = '0, m_new_sel = '0, m_old_base = '0, m_new_base = '0;
  bit order_err = 0;
  string scen = "";

  function automatic bit in_rec(input logic [15:0] a, input logic [15:0] b);
    return a >= b + 16'd1 && a <= b + 16'(N);
  endfunction

  // memory handshake and event log, all on the falling edge
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      acc_n++;
      if (mem_we && in_rec(mem_addr, m_old_base) && tr_sel != m_old_sel) order_err = 1;
      if (!mem_we && in_rec(mem_addr, m_new_base) && tr_sel != m_new_sel) order_err = 1;
    end
    mem_ack <= mem_req && !mem_ack;
    if (flag_we) begin
      if (flag_val) begin nset_n++; nset_sel = flag_sel; end
      else          begin oclr_n++; oclr_sel = flag_sel; end
    end
    if (done) done_n++;
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s [%s] actual=%h expected=%h", tag, scen, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [31:0] seed, input int k, input bit ntv);
    logic [31:0] w;
    w = seed + 32'(k) * 32'h0101_0101;
    if (k == 0) w[NT] = ntv;
    return w;
  endfunction

  task automatic wr_img(input logic [31:0] seed, input bit ntv);
    for (int k = 0; k < N; k++) begin
      @(negedge clk); img_we = 1'b1; img_idx = 3'(k); img_wd = pat(seed, k, ntv);
    end
    @(negedge clk); img_we = 1'b0;
  endtask

  task automatic poke(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); poke_en = 1'b1; poke_a = a[7:0]; poke_d = d;
    @(negedge clk); poke_en = 1'b0;
  endtask

  task automatic put_rec(input logic [15:0] b, input logic [31:0] seed, input bit ntv);
    poke(b, 32'hDEAD_0000);
    for (int k = 0; k < N; k++) poke(b + 16'(k + 1), pat(seed, k, ntv));
  endtask

  task automatic run(input string nm, input logic [2:0] c, input logic [15:0] s,
                     input logic [15:0] b, input logic [1:0] d, input logic [1:0] cp,
                     input bit pr, input logic [19:0] lm, input bit bz,
                     input logic [1:0] ef, input bit repulse);
    logic [31:0] isnap [N];
    logic [31:0] rsnap [N];
    logic [31:0] lsnap, e;
    logic [15:0] osel, obase, nsel;
    bit nst, got_f;
    logic [1:0] got_c;
    int w;
    scen = nm;
    for (int k = 0; k < N; k++) begin
      isnap[k] = img[k*32 +: 32];
      rsnap[k] = mem[8'(b + 16'(k + 1))];
    end
    lsnap = mem[b[7:0]];
    osel = tr_sel; obase = tr_base;
    nsel = (c == 3'd2) ? mem[obase[7:0]][15:0] : s;
    nst  = (c == 3'd1) || (c == 3'd3) || (c == 3'd4);
    m_old_sel = osel; m_old_base = obase; m_new_sel = nsel; m_new_base = b;
    acc_n = 0; oclr_n = 0; nset_n = 0; done_n = 0; order_err = 0;
    @(negedge clk);
    cause = c; sel = s; base = b; dpl = d; cpl = cp; present = pr; limit = lm; busy = bz;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    w = 0;
    while (!done && !fault && w < 400) begin
      start = (repulse && w == 6);
      @(negedge clk); w++;
    end
    start = 1'b0;
    got_f = fault; got_c = fcode;
    repeat (3) @(negedge clk);
    chk(w < 400, "R14", 32'(w), 32'd400);
    if (ef != 2'd0) begin
      chk(got_f && got_c == ef, "R5", {30'd0, got_c}, {30'd0, ef});
      chk(acc_n == 0 && oclr_n + nset_n == 0 && done_n == 0, "R5", 32'(acc_n), 32'd0);
      chk(tr_sel == osel && tr_base == obase, "R5", {tr_sel, tr_base}, {osel, obase});
      for (int k = 0; k < N; k++)
        chk(img[k*32 +: 32] == isnap[k], "R5", img[k*32 +: 32], isnap[k]);
    end else begin
      chk(!got_f && done_n == 1, "R14", 32'(done_n), 32'd1);
      for (int k = 0; k < N; k++) begin
        e = isnap[k];
        if (k == 0 && c == 3'd2) e[NT] = 1'b0;
        chk(mem[8'(obase + 16'(k + 1))] == e, (k == 0) ? "R11" : "R6",
            mem[8'(obase + 16'(k + 1))], e);
      end
      chk(tr_sel == nsel && tr_base == b, (c == 3'd2) ? "R13" : "R7",
          {tr_sel, tr_base}, {nsel, b});
      chk(!order_err, "R7", 32'(order_err), 32'd0);
      for (int k = 0; k < N; k++) begin
        e = rsnap[k];
        if (k == 0 && nst) e[NT] = 1'b1;
        chk(img[k*32 +: 32] == e, (k == 0) ? "R12" : "R9", img[k*32 +: 32], e);
      end
      e = nst ? {16'd0, osel} : lsnap;
      chk(mem[b[7:0]] == e, "R8", mem[b[7:0]], e);
      if (c == 3'd0 || c == 3'd2)
        chk(oclr_n == 1 && oclr_sel == osel, "R10", {16'(oclr_n), oclr_sel}, {16'd1, osel});
      else
        chk(oclr_n == 0, "R10", 32'(oclr_n), 32'd0);
      if (c != 3'd2)
        chk(nset_n == 1 && nset_sel == nsel, "R10", {16'(nset_n), nset_sel}, {16'd1, nsel});
      else
        chk(nset_n == 0, "R10", 32'(nset_n), 32'd0);
      chk(acc_n == 16 + ((nst || c == 3'd2) ? 1 : 0), repulse ? "R14" : "R6",
          32'(acc_n), 32'(16 + ((nst || c == 3'd2) ? 1 : 0)));
    end
  endtask

  task automatic t_reset;
    scen = "reset";
    chk(tr_sel == 16'h0010 && tr_base == 16'h0040, "R5", {tr_sel, tr_base}, 32'h0010_0040);
    chk(!done && !fault && !mem_req && !flag_we && !active, "R14",
        {27'd0, done, fault, mem_req, flag_we, active}, 32'd0);
    chk(img == '0, "R5", img[31:0], 32'd0);
  endtask

  task automatic t_priv;
    wr_img(32'h1100_0000, 1'b0);
    run("jmp cpl high",  3'd0, 16'h0020, 16'h0060, 2'd0, 2'd3, 1, 20'h67, 0, 2'd1, 0); // R1
    run("jmp rpl high",  3'd0, 16'h0023, 16'h0060, 2'd2, 2'd0, 1, 20'h67, 0, 2'd1, 0); // R1
    run("swint dpl low", 3'd3, 16'h0020, 16'h0060, 2'd0, 2'd2, 1, 20'h67, 0, 2'd1, 0); // R2
    run("gp over np",    3'd0, 16'h0020, 16'h0060, 2'd0, 2'd3, 0, 20'h67, 0, 2'd1, 0); // R3
  endtask

  task automatic t_desc;
    run("swint np",      3'd3, 16'h0020, 16'h0060, 2'd2, 2'd2, 0, 20'h67, 0, 2'd2, 0); // R3
    run("limit 0x66",    3'd0, 16'h0020, 16'h0060, 2'd3, 2'd0, 1, 20'h66, 0, 2'd2, 0); // R3
    run("jmp to busy",   3'd0, 16'h0020, 16'h0060, 2'd3, 2'd0, 1, 20'h67, 1, 2'd3, 0); // R4
    run("iret not busy", 3'd2, 16'h0020, 16'h0060, 2'd0, 2'd3, 1, 20'h67, 0, 2'd3, 0); // R4 R2
  endtask

  task automatic t_jmp;
    run("jmp ok", 3'd0, 16'h0020, 16'h0060, 2'd3, 2'd0, 1, 20'h67, 0, 2'd0, 0);
  endtask

  task automatic t_call;
    run("call ok repulse", 3'd1, 16'h0028, 16'h0080, 2'd3, 2'd0, 1, 20'h100, 0, 2'd0, 1);
  endtask

  task automatic t_iret;
    run("iret ok", 3'd2, 16'h0000, 16'h0060, 2'd0, 2'd3, 1, 20'h67, 1, 2'd0, 0);
  endtask

  task automatic t_ext;
    wr_img(32'h2200_0000, 1'b1);
    run("ext ok", 3'd4, 16'h0030, 16'h00A0, 2'd0, 2'd3, 1, 20'h67, 0, 2'd0, 0);
  endtask

  task automatic t_swint;
    run("swint ok", 3'd3, 16'h0038, 16'h00C0, 2'd3, 2'd3, 1, 20'h80, 0, 2'd0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    put_rec(16'h0060, 32'h6000_0000, 1'b1);
    put_rec(16'h0080, 32'h8000_0000, 1'b0);
    put_rec(16'h00A0, 32'hA000_0000, 1'b0);
    put_rec(16'h00C0, 32'hC000_0000, 1'b1);
    t_priv();
    t_desc();
    t_jmp();
    t_call();
    t_iret();
    t_ext();
    t_swint();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule